// File: doc/BRIEF.md
# Signal Free Time Gate

This block decides when a transmitter that has a message queued may start driving its start bit onto a shared single-wire consumer-electronics control bus. A pulse on `tx_arm` queues a request. The block waits while a reception is running. It then counts half nominal data-bit periods, marked by the one-cycle `half_tick` strobe, during which the line stays released. When the required amount of free bus time has passed, it raises `start_grant` for exactly one clock.

The required free time comes from a small configuration field. A non-zero value N asks for N minus one half bit periods. Zero selects automatic mode, in which the wait depends on how this node's own last attempt on the bus ended. The block keeps that history itself and updates it from the outcome pulse that the transmitter returns after each granted attempt. When an attempt loses arbitration, the request stays queued and the block counts the free time again on its own. Any other outcome clears the request.

Top module: `sft_gate`

## Requirements
- R1: After reset no request is pending, `start_grant` is low, and the history is "new initiator".
- R2: With `sft_cfg` = N (1..7), `start_grant` rises in the cycle after the edge that accepts the (2N-1)-th idle `half_tick`, counted from the first edge after counting starts.
- R3: With `sft_cfg` = 0 and history "new initiator", the wait is 8 idle half-ticks.
- R4: With `sft_cfg` = 0 after an attempt that ended with outcome code 0 (success), the wait is 12 idle half-ticks.
- R5: With `sft_cfg` = 0 after an attempt that ended with code 1 or 3 (error, underrun or missing acknowledge) or code 2 (arbitration lost), the wait is 5 idle half-ticks.
- R6: While `rx_busy` is high no count advances and no grant is issued. Raising `rx_busy` during counting returns the request to waiting and discards the partial count, even when it coincides with the final tick. Counting starts from zero in the edge after `rx_busy` falls.
- R7: A cycle with `line_idle` low during counting clears the idle count, so a full wait is needed after the line is released again.
- R8: Outcome code 2 keeps the request pending and starts a new free-time count without a new `tx_arm`. Codes 0, 1 and 3 end the request. Outcomes are accepted only while a grant is outstanding.
- R9: `enable` low cancels any request and count within one edge, and a `tx_arm` pulse while disabled is ignored.
- R10: `start_grant` is a single-cycle pulse that is issued only while a request is pending. A `tx_arm` pulse while a request is already pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Peripheral enable; low cancels everything |
| half_tick | input | 1 | One-cycle strobe per half nominal data-bit period |
| line_idle | input | 1 | High while the bus line is released (high level) |
| sft_cfg | input | CFG_W | Free-time selection; 0 = automatic |
| tx_arm | input | 1 | Pulse to queue a transmit request |
| rx_busy | input | 1 | High while a reception is in progress |
| outcome_valid | input | 1 | Pulse: the granted attempt has finished |
| outcome_kind | input | 2 | 0 success, 1 failure, 2 arbitration lost, 3 failure |
| start_grant | output | 1 | One-cycle pulse: start bit may be driven |
| req_pending | output | 1 | A request is queued, counting or granted |

## Verification
Reception start and the final free-time tick can land on the same clock edge. The bench provokes this by raising `rx_busy` in exactly the cycle that carries the half-tick which would complete the count. It expects no grant, and it expects the request to stay pending and later need a full fresh count. A behavioural model compares both outputs on every clock. Measured tick counts from arm (or release) to grant are judged against the per-mode wait lengths, including the waits reached after success, failure and arbitration loss.

// File: rtl/sft_gate_pkg.sv
package sft_gate_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_HOLD   = 2'd1,
      ST_COUNT  = 2'd2,
      ST_ACTIVE = 2'd3
   } gate_st_t;

   typedef enum logic [1:0] {
      HIST_NEW  = 2'd0,
      HIST_FAIL = 2'd1,
      HIST_OK   = 2'd2
   } hist_t;

   localparam logic [1:0] OUT_OK      = 2'd0;
   localparam logic [1:0] OUT_FAIL    = 2'd1;
   localparam logic [1:0] OUT_ARBLOST = 2'd2;

endpackage

// File: rtl/sft_hist.sv
module sft_hist
   import sft_gate_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       upd,
   input  logic [1:0] kind,
   output hist_t      hist_o
);

   hist_t hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= HIST_NEW;
      end else if (upd) begin
         hist_q <= (kind == OUT_OK) ? HIST_OK : HIST_FAIL;
      end
   end

   assign hist_o = hist_q;

   // success moves history to "last attempt succeeded"
   assert_hist_ok_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && kind == OUT_OK) |=> (hist_o == HIST_OK));

   // any non-success code, arbitration loss included, marks a failed attempt
   assert_hist_fail_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && kind != OUT_OK) |=> (hist_o == HIST_FAIL));

endmodule

// File: rtl/sft_target.sv
module sft_target
   import sft_gate_pkg::*;
#(
   parameter int CFG_W       = 3,
   parameter int CNT_W       = 4,
   parameter int FAIL_HALVES = 5,
   parameter int NEW_HALVES  = 8,
   parameter int OK_HALVES   = 12
) (
   input  logic [CFG_W-1:0] cfg,
   input  hist_t            hist,
   output logic [CNT_W-1:0] target
);

   logic [CNT_W-1:0] man_tgt;
   logic [CNT_W-1:0] auto_tgt;

   // manual selection N asks for N-0.5 bit periods = 2N-1 half periods
   assign man_tgt = CNT_W'({cfg, 1'b0}) - CNT_W'(1);

   always_comb begin
      unique case (hist)
         HIST_FAIL: auto_tgt = CNT_W'(FAIL_HALVES);
         HIST_OK:   auto_tgt = CNT_W'(OK_HALVES);
         default:   auto_tgt = CNT_W'(NEW_HALVES);
      endcase
   end

   assign target = (cfg == '0) ? auto_tgt : man_tgt;

endmodule

// File: rtl/sft_idle_cnt.sv
module sft_idle_cnt #(
   parameter int CNT_W       = 4,
   parameter bit LOW_RESTART = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             line_idle,
   input  logic [CNT_W-1:0] target,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic [CNT_W-1:0] low_val;

   assign done = run && tick && line_idle && (cnt_q == (target - CNT_W'(1)));

   generate
      if (LOW_RESTART) begin : g_restart
         assign low_val = '0;
      end else begin : g_pause
         assign low_val = cnt_q;
      end
   endgenerate

   always_comb begin
      cnt_d = cnt_q;
      if (!run) begin
         cnt_d = '0;
      end else if (!line_idle) begin
         cnt_d = low_val;
      end else if (tick) begin
         cnt_d = done ? '0 : cnt_q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   generate
      if (LOW_RESTART) begin : g_chk_restart
         // a driven-low line wipes the accumulated idle time
         assert_low_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (run && !line_idle) |=> (cnt_q == '0));
      end
   endgenerate

   // halting the count always discards it
   assert_stop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0));

endmodule

// File: rtl/sft_gate.sv
module sft_gate
   import sft_gate_pkg::*;
#(
   parameter int CFG_W            = 3,
   parameter int AUTO_FAIL_HALVES = 5,
   parameter int AUTO_NEW_HALVES  = 8,
   parameter int AUTO_OK_HALVES   = 12,
   parameter bit LOW_RESTART      = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             half_tick,
   input  logic             line_idle,
   input  logic [CFG_W-1:0] sft_cfg,
   input  logic             tx_arm,
   input  logic             rx_busy,
   input  logic             outcome_valid,
   input  logic [1:0]       outcome_kind,
   output logic             start_grant,
   output logic             req_pending
);

   localparam int MAN_MAX  = 2 * ((1 << CFG_W) - 1) - 1;
   localparam int AUTO_A   = (AUTO_FAIL_HALVES > AUTO_NEW_HALVES) ? AUTO_FAIL_HALVES : AUTO_NEW_HALVES;
   localparam int AUTO_MAX = (AUTO_A > AUTO_OK_HALVES) ? AUTO_A : AUTO_OK_HALVES;
   localparam int TGT_MAX  = (MAN_MAX > AUTO_MAX) ? MAN_MAX : AUTO_MAX;
   localparam int CNT_W    = $clog2(TGT_MAX + 1);

   generate
      if (CFG_W < 1 || CFG_W > 6) begin : g_bad_cfg_w
         $error("sft_gate: CFG_W must lie in 1..6");
      end
      if (AUTO_FAIL_HALVES < 1 || AUTO_NEW_HALVES < 1 || AUTO_OK_HALVES < 1) begin : g_bad_auto
         $error("sft_gate: automatic wait lengths must be at least one half period");
      end
   endgenerate

   gate_st_t         st_q, st_d;
   logic             grant_d, grant_q;
   logic             run, done, hist_upd;
   hist_t            hist;
   logic [CNT_W-1:0] target;

   assign run      = enable && (st_q == ST_COUNT) && !rx_busy;
   assign hist_upd = enable && (st_q == ST_ACTIVE) && outcome_valid;

   sft_hist u_hist (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd    (hist_upd),
      .kind   (outcome_kind),
      .hist_o (hist)
   );

   sft_target #(
      .CFG_W       (CFG_W),
      .CNT_W       (CNT_W),
      .FAIL_HALVES (AUTO_FAIL_HALVES),
      .NEW_HALVES  (AUTO_NEW_HALVES),
      .OK_HALVES   (AUTO_OK_HALVES)
   ) u_target (
      .cfg    (sft_cfg),
      .hist   (hist),
      .target (target)
   );

   sft_idle_cnt #(
      .CNT_W       (CNT_W),
      .LOW_RESTART (LOW_RESTART)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .tick      (half_tick),
      .line_idle (line_idle),
      .target    (target),
      .done      (done)
   );

   always_comb begin
      st_d    = st_q;
      grant_d = 1'b0;
      if (!enable) begin
         st_d = ST_IDLE;
      end else begin
         unique case (st_q)
            ST_IDLE:   if (tx_arm) st_d = rx_busy ? ST_HOLD : ST_COUNT;
            ST_HOLD:   if (!rx_busy) st_d = ST_COUNT;
            ST_COUNT: begin
               if (rx_busy) begin
                  st_d = ST_HOLD;
               end else if (done) begin
                  st_d    = ST_ACTIVE;
                  grant_d = 1'b1;
               end
            end
            ST_ACTIVE: begin
               if (outcome_valid)
                  st_d = (outcome_kind == OUT_ARBLOST) ? ST_COUNT : ST_IDLE;
            end
            default:   st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         grant_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         grant_q <= grant_d;
      end
   end

   assign start_grant = grant_q;
   assign req_pending = (st_q != ST_IDLE);

   assert_grant_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start_grant |=> !start_grant);

   assert_grant_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start_grant |-> req_pending);

   assert_rx_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_busy |=> !start_grant);

   assert_disable_cancels_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!req_pending && !start_grant));

   assert_arb_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hist_upd && outcome_kind == OUT_ARBLOST) |=> req_pending);

   assert_end_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hist_upd && outcome_kind != OUT_ARBLOST) |=> !req_pending);

endmodule

// File: tb/sft_gate_bench.sv
module sft_gate_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       half_tick = 1'b0;
   logic       line_idle = 1'b1;
   logic [2:0] sft_cfg = 3'd0;
   logic       tx_arm = 1'b0;
   logic       rx_busy = 1'b0;
   logic       outcome_valid = 1'b0;
   logic [1:0] outcome_kind = 2'd0;
   logic       start_grant;
   logic       req_pending;

   int compared = 0;
   int mismatched = 0;
   int divc = 0;
   string phase = "R1";

   // reference model state: 0 idle, 1 waiting on rx, 2 counting, 3 granted
   int m_st = 0;
   int m_cnt = 0;
   int m_hist = 0;  // 0 new, 1 failed, 2 succeeded
   int m_grant = 0;

   always #5 clk = ~clk;

   sft_gate u_sft_gate (
      .clk           (clk),
      .rst_n         (rst_n),
      .enable        (enable),
      .half_tick     (half_tick),
      .line_idle     (line_idle),
      .sft_cfg       (sft_cfg),
      .tx_arm        (tx_arm),
      .rx_busy       (rx_busy),
      .outcome_valid (outcome_valid),
      .outcome_kind  (outcome_kind),
      .start_grant   (start_grant),
      .req_pending   (req_pending)
   );

   function automatic int need(input int c, input int h);
      if (c != 0) return 2 * c - 1;
      if (h == 1) return 5;
      if (h == 2) return 12;
      return 8;
   endfunction

   always @(posedge clk) begin
      int g;
      g = 0;
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_hist = 0;
      end else if (!enable) begin
         m_st = 0; m_cnt = 0;
      end else begin
         case (m_st)
            0: if (tx_arm) begin m_st = rx_busy ? 1 : 2; m_cnt = 0; end
            1: if (!rx_busy) begin m_st = 2; m_cnt = 0; end
            2: begin
               if (rx_busy) begin
                  m_st = 1; m_cnt = 0;
               end else if (!line_idle) begin
                  m_cnt = 0;
               end else if (half_tick) begin
                  m_cnt = m_cnt + 1;
                  if (m_cnt >= need(int'(sft_cfg), m_hist)) begin
                     m_st = 3; m_cnt = 0; g = 1;
                  end
               end
            end
            default: if (outcome_valid) begin
               m_hist = (outcome_kind == 2'd0) ? 2 : 1;
               m_st   = (outcome_kind == 2'd2) ? 2 : 0;
               m_cnt  = 0;
            end
         endcase
      end
      m_grant = g;
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #2;
      check(int'(start_grant) == m_grant, phase, "start_grant vs model", int'(start_grant), m_grant);
      check(int'(req_pending) == (m_st != 0 ? 1 : 0), phase, "req_pending vs model",
            int'(req_pending), (m_st != 0 ? 1 : 0));
      divc = (divc + 1) % 4;
      half_tick = (divc == 0);
   endtask

   task automatic arm();
      tx_arm = 1'b1; cyc(); tx_arm = 1'b0;
   endtask

   task automatic outcome(input int k);
      outcome_valid = 1'b1; outcome_kind = 2'(k); cyc(); outcome_valid = 1'b0;
   endtask

   task automatic run_ticks(input int k);
      int left = k;
      while (left > 0) begin
         bit t = half_tick;
         cyc();
         if (t) left--;
      end
   endtask

   // counts accepted idle ticks until the grant appears, then checks it is one cycle wide
   task automatic expect_grant(input int exp, input string tag);
      int n = 0;
      int lim = 0;
      bit got = 1'b0;
      while (!got && lim < 400) begin
         bit t = half_tick && line_idle;
         cyc();
         lim++;
         if (t) n++;
         if (start_grant) got = 1'b1;
      end
      check(got && n == exp, tag, "idle half-ticks until grant", n, exp);
      cyc();
      check(start_grant == 1'b0, "R10", "grant width", int'(start_grant), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog run hung act=timeout exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      check(req_pending == 1'b0, "R1", "pending after reset", int'(req_pending), 0);
      check(start_grant == 1'b0, "R1", "grant after reset", int'(start_grant), 0);
      enable = 1'b1;
      cyc();

      // R1 R3: fresh history gives the new-initiator wait
      phase = "R3";
      arm();
      expect_grant(8, "R3");
      outcome(0);
      check(req_pending == 1'b0, "R8", "pending after success", int'(req_pending), 0);

      phase = "R4";
      arm();
      expect_grant(12, "R4");
      outcome(1);

      phase = "R5";
      arm();
      expect_grant(5, "R5");

      // R8: arbitration loss re-arms without a new request
      phase = "R8";
      outcome(2);
      check(req_pending == 1'b1, "R8", "pending after arbitration loss", int'(req_pending), 1);
      expect_grant(5, "R8");
      outcome(3);
      check(req_pending == 1'b0, "R8", "pending after failure code 3", int'(req_pending), 0);

      // R2: every manual selection
      phase = "R2";
      for (int n = 1; n < 8; n++) begin
         sft_cfg = 3'(n);
         arm();
         expect_grant(2 * n - 1, "R2");
         outcome(0);
      end

      // R7: low level restarts the idle count
      phase = "R7";
      sft_cfg = 3'd4;
      arm();
      run_ticks(3);
      line_idle = 1'b0;
      repeat (6) cyc();
      line_idle = 1'b1;
      expect_grant(7, "R7");
      outcome(0);

      // R6: request held during reception
      phase = "R6";
      sft_cfg = 3'd2;
      rx_busy = 1'b1;
      arm();
      run_ticks(5);
      check(req_pending == 1'b1, "R6", "pending while held", int'(req_pending), 1);
      rx_busy = 1'b0;
      cyc();
      expect_grant(3, "R6");
      outcome(0);

      // R6: reception starting on the final tick beats the grant
      arm();
      run_ticks(2);
      while (!half_tick) cyc();
      rx_busy = 1'b1;
      cyc();
      check(start_grant == 1'b0, "R6", "grant on collision", int'(start_grant), 0);
      cyc();
      check(req_pending == 1'b1, "R6", "pending after collision", int'(req_pending), 1);
      rx_busy = 1'b0;
      cyc();
      expect_grant(3, "R6");

      // R10: a request during an outstanding grant is ignored
      phase = "R10";
      arm();
      outcome(0);
      check(req_pending == 1'b0, "R10", "extra arm ignored", int'(req_pending), 0);

      // R9: disable aborts, arm while disabled ignored
      phase = "R9";
      arm();
      run_ticks(2);
      enable = 1'b0;
      cyc();
      check(req_pending == 1'b0, "R9", "pending after disable", int'(req_pending), 0);
      arm();
      enable = 1'b1;
      run_ticks(10);
      check(req_pending == 1'b0, "R9", "arm while disabled", int'(req_pending), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule